// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA Channel

This block is a single receive DMA channel that copies data arriving from a USB OUT endpoint into system memory. It walks a list of descriptors kept in memory, one after another. Software writes the address of the first descriptor and then a control word that arms the channel. The channel does nothing until the endpoint reports that a packet has been stored. It then raises its active flag and, a fixed number of cycles later, reads the descriptor. It copies payload words from the endpoint stream to the destination the descriptor names, and follows the chain.

A descriptor is three consecutive 32-bit words. Word 0 is the address of the next descriptor, word 1 is the destination address and word 2 is a control word. Control word layout: bit 0 enables the transfer, bit 1 asks for the next descriptor to be loaded afterwards, and bits 31:16 hold the byte count. A descriptor with bit 1 at 0 ends the chain. When the chain ends, the channel returns to idle and pulses an end-of-chain interrupt.

Top module: `rxchain_dma`

## Requirements
- R1: After reset all four status outputs, the interrupt, and both memory request outputs are 0, and the channel is idle.
- R2: A register write with `cfg_sel`=1 (control) whose bit 1 is 1 arms the channel. `st_ld_pend` reads 1 and `st_chan_en` reads 0. No memory read is issued until `ep_pkt` is seen.
- R3: When `ep_pkt` is high while armed, `st_active` is 1 on the next cycle. The first descriptor read starts no earlier than `WAKE_CYC` cycles after that.
- R4: A descriptor is fetched as three single-word reads at its base, base+4 and base+8, taken as next address, destination and control. `st_loaded` is 1 once the third word has arrived.
- R5: Control word bit 0 is transfer enable, bit 1 is load-next, and bits 31:16 are the byte count. Bits 15:2 are ignored.
- R6: Payload words go to consecutive word addresses from the destination upward. `mw_be` is 4'hF for full words. The final word of a count that is not a multiple of 4 gets the low (count mod 4) enables set: 4'h1, 4'h3 or 4'h7.
- R7: `st_chan_en` is 1 while a descriptor's payload is being written. It returns to 0 one cycle after the internal enable clears at the end of the byte count.
- R8: After a descriptor whose load-next bit is 1, the next descriptor is fetched from the stored next address without waiting for a new `ep_pkt`. A descriptor with enable 0 moves no data.
- R9: After a descriptor with load-next 0 completes, `st_active` drops and `irq_eoc` is 1 for exactly one cycle.
- R10: Register writes of either kind are ignored while `st_active` is 1.
- R11: A control write with bit 1 at 0 while armed disarms the channel. `st_ld_pend` reads 0 and a later `ep_pkt` starts nothing.
- R12: An enabled descriptor with byte count 0 issues no memory write and completes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = next-descriptor pointer, 1 = control word |
| cfg_wdata | input | 32 | Register write data |
| ep_pkt | input | 1 | Endpoint reports a stored OUT packet |
| ep_valid | input | 1 | Endpoint payload word available |
| ep_data | input | 32 | Endpoint payload word |
| ep_take | output | 1 | Payload word consumed this cycle |
| mr_req | output | 1 | Memory read request |
| mr_addr | output | AW | Memory read address |
| mr_gnt | input | 1 | Memory read request accepted |
| mr_rvalid | input | 1 | Memory read data valid |
| mr_rdata | input | 32 | Memory read data |
| mw_req | output | 1 | Memory write request |
| mw_addr | output | AW | Memory write address |
| mw_data | output | 32 | Memory write data |
| mw_be | output | 4 | Memory write byte enables |
| mw_gnt | input | 1 | Memory write accepted |
| st_chan_en | output | 1 | Status: transfer enabled |
| st_active | output | 1 | Status: channel active |
| st_loaded | output | 1 | Status: descriptor loaded |
| st_ld_pend | output | 1 | Status: armed, waiting for endpoint |
| irq_eoc | output | 1 | End-of-chain pulse |

## Verification
The checker watches several cycle-level rules on every cycle:
- a read request only ever appears while the channel is active;
- an armed channel issues no memory traffic;
- reads and writes are never requested together;
- every write carries a legal byte-enable pattern and happens under the enable;
- the end-of-chain pulse lasts one cycle and coincides with the channel being inactive.

The scenarios in the bench must show the rest:
- descriptor addresses and field decoding;
- the payload write sequence and the masking of its last word;
- chaining and the skipping of disabled descriptors;
- zero-length descriptors;
- disarming;
- register writes being ignored during activity.

// File: rtl/rxchain_pkg.sv
`timescale 1ns/1ps
// Shared constants, sequencer states and helpers for the chained receive DMA.
// Assumes a 32-bit control word whose field positions are fixed here.
package rxchain_pkg;
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_LD_BIT  = 1;
    localparam int CTL_LEN_LSB = 16;
    localparam int CTL_LEN_W   = 16;
    localparam int DESC_WORDS  = 3;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_PEND,
        SQ_WAKE,
        SQ_FETCH,
        SQ_MOVE,
        SQ_STEP
    } seq_t;

    // Byte enables for a final word holding 1..3 bytes (low bytes first).
    function automatic logic [3:0] tail_be(input logic [1:0] nbytes);
        case (nbytes)
            2'd1:    return 4'b0001;
            2'd2:    return 4'b0011;
            2'd3:    return 4'b0111;
            default: return 4'b1111;
        endcase
    endfunction
endpackage

// File: rtl/rxchain_fetch.sv
`timescale 1ns/1ps
// Descriptor fetcher: on a start pulse reads DESC_WORDS consecutive words
// from base, one single-word read at a time on a valid/ready request port
// with a separate read-data valid. Pulses done when the last word arrived.
// Assumes at most one read outstanding and AW <= 32.
module rxchain_fetch
    import rxchain_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base,
    output logic          mr_req,
    output logic [AW-1:0] mr_addr,
    input  logic          mr_gnt,
    input  logic          mr_rvalid,
    input  logic [31:0]   mr_rdata,
    output logic          done,
    output logic [AW-1:0] w_next,
    output logic [AW-1:0] w_dest,
    output logic [31:0]   w_ctrl
);
    localparam int IW = $clog2(DESC_WORDS);

    logic          busy;
    logic          waiting;
    logic [IW-1:0] idx;
    logic [AW-1:0] base_r;
    logic [31:0]   wbuf [DESC_WORDS];

    // Read request sequencing and capture of returned words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            waiting <= 1'b0;
            idx     <= '0;
            base_r  <= '0;
            done    <= 1'b0;
            for (int i = 0; i < DESC_WORDS; i++) wbuf[i] <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                waiting <= 1'b0;
                idx     <= '0;
                base_r  <= base;
            end else if (busy) begin
                if (!waiting && mr_gnt) begin
                    waiting <= 1'b1;
                end else if (waiting && mr_rvalid) begin
                    wbuf[idx] <= mr_rdata;
                    waiting   <= 1'b0;
                    if (idx == IW'(DESC_WORDS - 1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    // Request and word-address generation.
    always_comb begin
        mr_req  = busy && !waiting;
        mr_addr = base_r + (AW'(idx) << 2);
    end

    // Descriptor field extraction.
    always_comb begin
        w_next = AW'(wbuf[0]);
        w_dest = AW'(wbuf[1]);
        w_ctrl = wbuf[2];
    end
endmodule

// File: rtl/rxchain_mover.sv
`timescale 1ns/1ps
// Payload mover: on a start pulse copies len bytes from the endpoint word
// stream to memory at dest, one word per write. The final partial word is
// masked. Pulses done when the count reaches zero; a zero count finishes
// at once. Assumes dest is word aligned and len is stable at start.
module rxchain_mover
    import rxchain_pkg::*;
#(
    parameter int AW    = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    dest,
    input  logic [LEN_W-1:0] len,
    input  logic             ep_valid,
    input  logic [31:0]      ep_data,
    output logic             ep_take,
    output logic             mw_req,
    output logic [AW-1:0]    mw_addr,
    output logic [31:0]      mw_data,
    output logic [3:0]       mw_be,
    input  logic             mw_gnt,
    output logic             done
);
    localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

    logic             busy;
    logic             wpend;
    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] step;

    // Bytes retired by the word now being written.
    always_comb begin
        step    = (rem >= WORD_BYTES) ? WORD_BYTES : rem;
        ep_take = busy && !wpend && ep_valid;
        mw_req  = wpend;
    end

    // Word capture, write handshake and byte countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            wpend   <= 1'b0;
            rem     <= '0;
            mw_addr <= '0;
            mw_data <= '0;
            mw_be   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                wpend   <= 1'b0;
                rem     <= len;
                mw_addr <= dest;
                if (len == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (ep_take) begin
                mw_data <= ep_data;
                mw_be   <= (rem >= WORD_BYTES) ? 4'hF : tail_be(rem[1:0]);
                wpend   <= 1'b1;
            end else if (wpend && mw_gnt) begin
                wpend   <= 1'b0;
                mw_addr <= mw_addr + AW'(4);
                rem     <= rem - step;
                if (rem <= WORD_BYTES) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rxchain_dma.sv
`timescale 1ns/1ps
// Chained receive DMA channel top. Holds the pointer and control registers,
// arms on a control write with load-next set, waits for the endpoint packet
// event, then fetches descriptors and moves payload until a descriptor with
// load-next clear completes. Assumes descriptors are word aligned.
module rxchain_dma
    import rxchain_pkg::*;
#(
    parameter int AW       = 32,
    parameter int WAKE_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          ep_pkt,
    input  logic          ep_valid,
    input  logic [31:0]   ep_data,
    output logic          ep_take,
    output logic          mr_req,
    output logic [AW-1:0] mr_addr,
    input  logic          mr_gnt,
    input  logic          mr_rvalid,
    input  logic [31:0]   mr_rdata,
    output logic          mw_req,
    output logic [AW-1:0] mw_addr,
    output logic [31:0]   mw_data,
    output logic [3:0]    mw_be,
    input  logic          mw_gnt,
    output logic          st_chan_en,
    output logic          st_active,
    output logic          st_loaded,
    output logic          st_ld_pend,
    output logic          irq_eoc
);
    localparam int WCW = $clog2(WAKE_CYC + 1);

    seq_t                 state;
    logic [AW-1:0]        nxt_ptr;
    logic [AW-1:0]        dest_r;
    logic                 ctrl_en;
    logic                 ctrl_ld;
    logic [CTL_LEN_W-1:0] len_r;
    logic [WCW-1:0]       wake_cnt;
    logic                 fetch_start;
    logic                 mv_start;
    logic                 f_done;
    logic                 mv_done;
    logic [AW-1:0]        f_next;
    logic [AW-1:0]        f_dest;
    logic [31:0]          f_ctrl;
    logic                 cfg_ok;
    logic                 unused_bits;

    // Register writes are accepted only while the channel is not active.
    always_comb begin
        cfg_ok      = cfg_we && !st_active;
        unused_bits = ^{cfg_wdata[CTL_LEN_LSB-1:2], f_ctrl[CTL_LEN_LSB-1:2]};
    end

    // Channel sequencer, configuration registers and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_IDLE;
            nxt_ptr     <= '0;
            dest_r      <= '0;
            ctrl_en     <= 1'b0;
            ctrl_ld     <= 1'b0;
            len_r       <= '0;
            wake_cnt    <= '0;
            fetch_start <= 1'b0;
            mv_start    <= 1'b0;
            st_chan_en  <= 1'b0;
            st_active   <= 1'b0;
            st_loaded   <= 1'b0;
            st_ld_pend  <= 1'b0;
            irq_eoc     <= 1'b0;
        end else begin
            fetch_start <= 1'b0;
            mv_start    <= 1'b0;
            irq_eoc     <= 1'b0;
            st_chan_en  <= ctrl_en;
            case (state)
                SQ_IDLE, SQ_PEND: begin
                    if (cfg_ok && !cfg_sel) begin
                        nxt_ptr <= AW'(cfg_wdata);
                    end
                    if (cfg_ok && cfg_sel) begin
                        ctrl_en    <= 1'b0;
                        ctrl_ld    <= cfg_wdata[CTL_LD_BIT];
                        len_r      <= cfg_wdata[CTL_LEN_LSB +: CTL_LEN_W];
                        st_loaded  <= 1'b0;
                        st_ld_pend <= cfg_wdata[CTL_LD_BIT];
                        state      <= cfg_wdata[CTL_LD_BIT] ? SQ_PEND : SQ_IDLE;
                    end else if (state == SQ_PEND && ep_pkt) begin
                        st_active <= 1'b1;
                        wake_cnt  <= '0;
                        state     <= SQ_WAKE;
                    end
                end
                SQ_WAKE: begin
                    if (wake_cnt == WCW'(WAKE_CYC - 1)) begin
                        fetch_start <= 1'b1;
                        st_ld_pend  <= 1'b0;
                        state       <= SQ_FETCH;
                    end else begin
                        wake_cnt <= wake_cnt + 1'b1;
                    end
                end
                SQ_FETCH: begin
                    if (f_done) begin
                        nxt_ptr   <= f_next;
                        dest_r    <= f_dest;
                        ctrl_en   <= f_ctrl[CTL_EN_BIT];
                        ctrl_ld   <= f_ctrl[CTL_LD_BIT];
                        len_r     <= f_ctrl[CTL_LEN_LSB +: CTL_LEN_W];
                        st_loaded <= 1'b1;
                        if (f_ctrl[CTL_EN_BIT]) begin
                            mv_start <= 1'b1;
                            state    <= SQ_MOVE;
                        end else begin
                            state <= SQ_STEP;
                        end
                    end
                end
                SQ_MOVE: begin
                    if (mv_done) begin
                        ctrl_en <= 1'b0;
                        state   <= SQ_STEP;
                    end
                end
                SQ_STEP: begin
                    if (ctrl_ld) begin
                        fetch_start <= 1'b1;
                        st_loaded   <= 1'b0;
                        state       <= SQ_FETCH;
                    end else begin
                        st_active <= 1'b0;
                        irq_eoc   <= 1'b1;
                        state     <= SQ_IDLE;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    rxchain_fetch #(.AW(AW)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (fetch_start),
        .base      (nxt_ptr),
        .mr_req    (mr_req),
        .mr_addr   (mr_addr),
        .mr_gnt    (mr_gnt),
        .mr_rvalid (mr_rvalid),
        .mr_rdata  (mr_rdata),
        .done      (f_done),
        .w_next    (f_next),
        .w_dest    (f_dest),
        .w_ctrl    (f_ctrl)
    );

    rxchain_mover #(.AW(AW), .LEN_W(CTL_LEN_W)) u_mover (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (mv_start),
        .dest     (dest_r),
        .len      (len_r),
        .ep_valid (ep_valid),
        .ep_data  (ep_data),
        .ep_take  (ep_take),
        .mw_req   (mw_req),
        .mw_addr  (mw_addr),
        .mw_data  (mw_data),
        .mw_be    (mw_be),
        .mw_gnt   (mw_gnt),
        .done     (mv_done)
    );
endmodule

// File: rtl/rxchain_dma_chk.sv
`timescale 1ns/1ps
// Cycle-level protocol checker for rxchain_dma, attached by bind below.
// Assumes synchronous active-low reset on rst_n.
module rxchain_dma_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mr_req,
    input logic       mw_req,
    input logic [3:0] mw_be,
    input logic       ctrl_en,
    input logic       st_active,
    input logic       st_ld_pend,
    input logic       irq_eoc
);
    // R2: an armed channel waiting for the endpoint makes no memory traffic.
    p_quiet_when_armed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_ld_pend |-> (!mr_req && !mw_req));

    // R3: descriptor reads only happen once the channel is active.
    p_read_needs_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mr_req |-> st_active);

    // R6: write enables are a full word or a low-aligned partial word.
    p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mw_req |-> (mw_be == 4'hF || mw_be == 4'h7 || mw_be == 4'h3 || mw_be == 4'h1));

    // R6: reads and writes are never requested in the same cycle.
    p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mr_req && mw_req));

    // R7: payload writes happen only while the transfer enable is set.
    p_write_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mw_req |-> ctrl_en);

    // R9: the end-of-chain pulse lasts one cycle.
    p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eoc |=> !irq_eoc);

    // R9: the end-of-chain pulse arrives with the channel no longer active.
    p_irq_inactive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eoc |-> !st_active);
endmodule

bind rxchain_dma rxchain_dma_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mr_req     (mr_req),
    .mw_req     (mw_req),
    .mw_be      (mw_be),
    .ctrl_en    (ctrl_en),
    .st_active  (st_active),
    .st_ld_pend (st_ld_pend),
    .irq_eoc    (irq_eoc)
);

// File: tb/sim_rxchain_dma.sv
`timescale 1ns/1ps
// Directed bench for rxchain_dma: memory and endpoint models plus one task per scenario.
module sim_rxchain_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        ep_pkt = 1'b0;
    logic        ep_valid = 1'b1;
    logic [31:0] ep_data;
    logic        ep_take;
    logic        mr_req;
    logic [31:0] mr_addr;
    logic        mr_gnt = 1'b1;
    logic        mr_rvalid = 1'b0;
    logic [31:0] mr_rdata = '0;
    logic        mw_req;
    logic [31:0] mw_addr;
    logic [31:0] mw_data;
    logic [3:0]  mw_be;
    logic        mw_gnt = 1'b1;
    logic        st_chan_en, st_active, st_loaded, st_ld_pend, irq_eoc;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    rxchain_dma u0 (.*);

    // Memory, endpoint stream and logs.
    logic [31:0] mem [0:63];
    logic        acc = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [15:0] scnt = '0;
    int          rn = 0, wn = 0;
    logic [31:0] rlog [0:63];
    logic [31:0] wa [0:63];
    logic [31:0] wd [0:63];
    logic [3:0]  wb [0:63];

    assign ep_data = 32'hD000_0000 | 32'(scnt);

    always @(posedge clk) begin
        acc      <= mr_req && mr_gnt;
        acc_addr <= mr_addr;
        if (mr_req && mr_gnt) begin rlog[rn % 64] <= mr_addr; rn <= rn + 1; end
        if (mw_req && mw_gnt) begin
            wa[wn % 64] <= mw_addr; wd[wn % 64] <= mw_data; wb[wn % 64] <= mw_be;
            wn <= wn + 1;
        end
        if (ep_take) scnt <= scnt + 1'b1;
    end

    always @(negedge clk) begin
        mr_rvalid = acc;
        mr_rdata  = mem[acc_addr[7:2]];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [31:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_pkt();
        @(negedge clk); ep_pkt = 1'b1;
        @(negedge clk); ep_pkt = 1'b0;
    endtask

    task automatic run_to_irq(output int irqs, output bit en_seen);
        irqs = 0; en_seen = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (st_chan_en) en_seen = 1;
            if (irq_eoc) begin
                irqs++;
                @(negedge clk);
                if (irq_eoc) irqs++;
                break;
            end
        end
    endtask

    task automatic put_desc(input int at, input logic [31:0] nx, input logic [31:0] ds, input logic [31:0] ct);
        mem[at/4] = nx; mem[at/4 + 1] = ds; mem[at/4 + 2] = ct;
    endtask

    // R1: reset state.
    task automatic t_reset();
        chk({st_chan_en, st_active, st_loaded, st_ld_pend} == 4'b0, "R1 status", 32'({st_chan_en, st_active, st_loaded, st_ld_pend}), 0);
        chk(!mr_req && !mw_req && !irq_eoc, "R1 requests/irq", 32'({mr_req, mw_req, irq_eoc}), 0);
    endtask

    // R2..R7, R9: single 10-byte descriptor.
    task automatic t_single();
        int irqs; bit en_seen; int r0, w0; logic [15:0] s0;
        put_desc(32'h40, 32'h0, 32'h200, 32'h000A_0001); // R5: len 10, en 1, ld 0
        r0 = rn; w0 = wn; s0 = scnt;
        cfg_write(1'b0, 32'h40);
        cfg_write(1'b1, 32'h0000_0002);
        chk(st_ld_pend == 1'b1, "R2 ld_pend", 32'(st_ld_pend), 1);
        chk(st_chan_en == 1'b0, "R2 chan_en", 32'(st_chan_en), 0);
        repeat (10) @(negedge clk);
        chk(rn == r0, "R2 no read before packet", rn - r0, 0);
        pulse_pkt();
        chk(st_active == 1'b1, "R3 active", 32'(st_active), 1);
        chk(mr_req == 1'b0, "R3 fetch delayed", 32'(mr_req), 0);
        run_to_irq(irqs, en_seen);
        chk(irqs == 1, "R9 irq one cycle", irqs, 1);
        chk(st_active == 1'b0, "R9 inactive", 32'(st_active), 0);
        chk(rn - r0 == 3, "R4 read count", rn - r0, 3);
        for (int k = 0; k < 3; k++)
            chk(rlog[(r0 + k) % 64] == 32'h40 + 4*k, "R4 read addr", rlog[(r0 + k) % 64], 32'h40 + 4*k);
        chk(st_loaded == 1'b1, "R4 loaded", 32'(st_loaded), 1);
        chk(wn - w0 == 3, "R5 write count from len", wn - w0, 3);
        for (int k = 0; k < 3; k++) begin
            chk(wa[(w0 + k) % 64] == 32'h200 + 4*k, "R6 write addr", wa[(w0 + k) % 64], 32'h200 + 4*k);
            chk(wd[(w0 + k) % 64] == (32'hD000_0000 | 32'(s0 + 16'(k))), "R6 write data", wd[(w0 + k) % 64], 32'hD000_0000 | 32'(s0 + 16'(k)));
        end
        chk(wb[(w0 + 1) % 64] == 4'hF, "R6 full be", 32'(wb[(w0 + 1) % 64]), 32'hF);
        chk(wb[(w0 + 2) % 64] == 4'h3, "R6 tail be", 32'(wb[(w0 + 2) % 64]), 32'h3);
        chk(en_seen, "R7 chan_en during move", 32'(en_seen), 1);
        chk(st_chan_en == 1'b0, "R7 chan_en after", 32'(st_chan_en), 0);
    endtask

    // R8, R10: three-descriptor chain with a disabled middle link and ignored writes.
    task automatic t_chain();
        int irqs; bit en_seen; int r0, w0;
        put_desc(32'h80, 32'h90, 32'h300, 32'h0008_0003);
        put_desc(32'h90, 32'hA0, 32'h340, 32'h000C_0002);
        put_desc(32'hA0, 32'h0, 32'h380, 32'h0005_0001);
        r0 = rn; w0 = wn;
        cfg_write(1'b0, 32'h80);
        cfg_write(1'b1, 32'h0000_0002);
        pulse_pkt();
        cfg_write(1'b1, 32'h0000_0000); // R10: ignored while active
        cfg_write(1'b0, 32'h40);        // R10: ignored while active
        chk(st_ld_pend == 1'b0, "R10 ctrl write ignored", 32'(st_ld_pend), 0);
        run_to_irq(irqs, en_seen);
        chk(irqs == 1, "R9 chain end irq", irqs, 1);
        chk(rn - r0 == 9, "R8 chain reads", rn - r0, 9);
        chk(rlog[(r0 + 3) % 64] == 32'h90, "R8/R10 second desc addr", rlog[(r0 + 3) % 64], 32'h90);
        chk(rlog[(r0 + 6) % 64] == 32'hA0, "R8 third desc addr", rlog[(r0 + 6) % 64], 32'hA0);
        chk(wn - w0 == 4, "R8 disabled desc moves nothing", wn - w0, 4);
        chk(wa[(w0 + 2) % 64] == 32'h380, "R8 third dest", wa[(w0 + 2) % 64], 32'h380);
        chk(wb[(w0 + 3) % 64] == 4'h1, "R6 1-byte tail be", 32'(wb[(w0 + 3) % 64]), 32'h1);
    endtask

    // R11: disarm while pending.
    task automatic t_disarm();
        int r0;
        r0 = rn;
        cfg_write(1'b0, 32'h40);
        cfg_write(1'b1, 32'h0000_0002);
        cfg_write(1'b1, 32'h0000_0000);
        chk(st_ld_pend == 1'b0, "R11 disarmed", 32'(st_ld_pend), 0);
        pulse_pkt();
        repeat (8) @(negedge clk);
        chk(st_active == 1'b0, "R11 no start", 32'(st_active), 0);
        chk(rn == r0, "R11 no reads", rn - r0, 0);
    endtask

    // R12: enabled descriptor with zero length.
    task automatic t_zero();
        int irqs; bit en_seen; int w0;
        put_desc(32'h60, 32'h0, 32'h400, 32'h0000_0001);
        w0 = wn;
        cfg_write(1'b0, 32'h60);
        cfg_write(1'b1, 32'h0000_0002);
        pulse_pkt();
        run_to_irq(irqs, en_seen);
        chk(irqs == 1, "R12 completes", irqs, 1);
        chk(wn == w0, "R12 no writes", wn - w0, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_chain();
        t_disarm();
        t_zero();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R9 watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule